// File: doc/BRIEF.md
# CAN Error Flag Capture Unit

This unit holds the error status word of one CAN channel. A protocol engine sends single-cycle event pulses for each kind of fault it finds. These are ACK-delimiter form error, bit-0 error, bit-1 error, CRC error, ACK error, form error, stuff error, lost arbitration and overload condition. Each pulse latches a sticky flag. Software reads the word at any time and clears a flag by writing 0 to its bit position. A write of 1 has no effect, and a hardware set always beats a software clear that lands in the same cycle.

An optional first-error mode keeps only the first protocol error. In that mode a new protocol event is dropped while any of the seven protocol flags is still set.

A built-in bus-lock detector counts consecutive dominant samples delivered on a bit strobe. On the 32nd consecutive dominant sample it raises its own flag. It then stays disarmed until one of two things happens: a recessive sample arrives after software has cleared the flag, or the channel passes through reset mode. An interrupt line is raised whenever any flag is set. The register port is a plain write strobe with a combinational read word; no stream interface is present, so no back-pressure applies.

Top module: `can_err_flags`

## Requirements
- R1: After `rst_n` is released, `reg_rdata` reads 16'h0000 and `err_irq` is 0.
- R2: In communication mode (`chan_comm`=1), an event pulse sets its flag, visible on `reg_rdata` in the cycle after the edge that sampled it. The bit positions are: ACK-delimiter 14, bit-0 13, bit-1 12, CRC 11, ACK 10, form 9, stuff 8, arbitration lost 2, bus lock 1, overload 0.
- R3: A write (`reg_wr`=1) clears every flag whose `reg_wdata` bit is 0 and leaves every flag whose `reg_wdata` bit is 1 unchanged; a write never sets a flag.
- R4: When a flag's set event and a write of 0 to that flag fall in the same cycle, the flag is 1 afterwards.
- R5: While `chan_comm`=0 (reset mode), all flags are forced to 0 and event pulses are ignored.
- R6: With `all_err_en`=0, a protocol event (bits 14..8) sets its flag only if bits 14..8 are all 0 before that edge. Arbitration-lost and overload are set regardless.
- R7: With `all_err_en`=1, every protocol event sets its own flag whatever the other flags hold.
- R8: With `bus_bit` 0 meaning dominant and 1 meaning recessive, 32 consecutive dominant samples on `bit_strobe` in communication mode set bit 1. 31 samples do not, and a recessive sample restarts the count.
- R9: After a bus-lock detection, further dominant runs set nothing until a recessive sample arrives while bit 1 reads 0. A recessive sample taken while bit 1 is still set does not re-arm the detector.
- R10: A pass through reset mode re-arms the bus-lock detector, so 32 dominant samples afterwards set bit 1 again.
- R11: `err_irq` is 1 exactly when `reg_rdata` is non-zero.
- R12: Bits 15 and 7..3 of `reg_rdata` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_comm | input | 1 | 1 = communication mode, 0 = channel reset mode |
| all_err_en | input | 1 | 1 = record every protocol error, 0 = first protocol error only |
| ev_ack_delim | input | 1 | ACK-delimiter form error pulse (transmit) |
| ev_bit0 | input | 1 | Drove dominant, sampled recessive |
| ev_bit1 | input | 1 | Drove recessive, sampled dominant |
| ev_crc | input | 1 | CRC error pulse |
| ev_ack | input | 1 | ACK error pulse |
| ev_form | input | 1 | Form error pulse |
| ev_stuff | input | 1 | Stuff error pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_overload | input | 1 | Overload-frame condition pulse (receive or transmit) |
| bit_strobe | input | 1 | One pulse per sampled bus bit |
| bus_bit | input | 1 | Sampled level, 0 dominant, 1 recessive |
| reg_wr | input | 1 | Write strobe for the flag word |
| reg_wdata | input | 16 | Write data; a 0 bit clears the flag |
| reg_rdata | output | 16 | Current flag word, zero latency |
| err_irq | output | 1 | OR of all flags |

## Verification
The bench drives a write of 0 in the same cycle as a set event. A design where the clear wins would lose the arbitration-lost flag. In first-error mode it sends a second protocol event while one flag is held; a gate that was missing or used the wrong bit range would latch the second error. For bus lock it checks the run boundary (31 against 32 dominant samples). It also checks that a recessive sample taken before the flag is cleared does not re-arm the detector, and that a pass through reset mode does re-arm it. A detector that forgot the armed state, or re-armed too early, would raise the flag again.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int FLAG_W    = 16;
  localparam int B_ADELIM  = 14;
  localparam int B_BIT0    = 13;
  localparam int B_BIT1    = 12;
  localparam int B_CRC     = 11;
  localparam int B_ACK     = 10;
  localparam int B_FORM    = 9;
  localparam int B_STUFF   = 8;
  localparam int B_ARB     = 2;
  localparam int B_LOCK    = 1;
  localparam int B_OVL     = 0;
  localparam int PROTO_HI  = 14;
  localparam int PROTO_LO  = 8;
  localparam logic [FLAG_W-1:0] IMPL_MASK = 16'h7F07;

  typedef struct packed {
    logic ack_delim;
    logic bit0;
    logic bit1;
    logic crc;
    logic ack;
    logic form;
    logic stuff;
    logic arb;
    logic ovl;
  } err_ev_t;
endpackage

// File: rtl/can_err_gate.sv
module can_err_gate
  import can_err_pkg::*;
(
  input  err_ev_t           ev,
  input  logic              lock_set,
  input  logic              all_err_en,
  input  logic              proto_busy,
  output logic [FLAG_W-1:0] set_vec
);
  logic proto_ok;
  logic [FLAG_W-1:0] raw;

  // protocol errors pass when every error is kept, or when none is held yet
  assign proto_ok = all_err_en | ~proto_busy;

  always_comb begin
    raw           = '0;
    raw[B_ADELIM] = ev.ack_delim & proto_ok;
    raw[B_BIT0]   = ev.bit0      & proto_ok;
    raw[B_BIT1]   = ev.bit1      & proto_ok;
    raw[B_CRC]    = ev.crc       & proto_ok;
    raw[B_ACK]    = ev.ack       & proto_ok;
    raw[B_FORM]   = ev.form      & proto_ok;
    raw[B_STUFF]  = ev.stuff     & proto_ok;
    raw[B_ARB]    = ev.arb;
    raw[B_LOCK]   = lock_set;
    raw[B_OVL]    = ev.ovl;
    set_vec       = raw & IMPL_MASK;
  end
endmodule

// File: rtl/can_err_cell.sv
module can_err_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic comm,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (!comm) q <= 1'b0;
    else            q <= (q & ~clr) | set;  // set dominates clear
  end
endmodule

// File: rtl/can_err_lock.sv
module can_err_lock #(
  parameter int LOCK_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic comm,
  input  logic strobe,
  input  logic level,
  input  logic flag_now,
  output logic lock_set
);
  localparam int CNT_W = $clog2(LOCK_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_BITS - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(LOCK_BITS);

  logic [CNT_W-1:0] run_q;
  logic             armed_q;
  logic             dom;

  assign dom      = comm & strobe & ~level;
  assign lock_set = dom & armed_q & (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b1;
    end else if (!comm) begin
      run_q   <= '0;
      armed_q <= 1'b1;
    end else if (strobe) begin
      if (level) begin
        run_q <= '0;
        if (!armed_q && !flag_now) armed_q <= 1'b1;
      end else if (armed_q) begin
        if (lock_set) begin
          run_q   <= '0;
          armed_q <= 1'b0;
        end else if (run_q != TOP) begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/can_err_flags.sv
module can_err_flags
  import can_err_pkg::*;
#(
  parameter int LOCK_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_comm,
  input  logic              all_err_en,
  input  logic              ev_ack_delim,
  input  logic              ev_bit0,
  input  logic              ev_bit1,
  input  logic              ev_crc,
  input  logic              ev_ack,
  input  logic              ev_form,
  input  logic              ev_stuff,
  input  logic              ev_arb_lost,
  input  logic              ev_overload,
  input  logic              bit_strobe,
  input  logic              bus_bit,
  input  logic              reg_wr,
  input  logic [FLAG_W-1:0] reg_wdata,
  output logic [FLAG_W-1:0] reg_rdata,
  output logic              err_irq
);
  err_ev_t           ev;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;
  logic              lock_set;

  assign ev = '{ack_delim: ev_ack_delim, bit0: ev_bit0, bit1: ev_bit1,
                crc: ev_crc, ack: ev_ack, form: ev_form, stuff: ev_stuff,
                arb: ev_arb_lost, ovl: ev_overload};

  assign clr_vec = {FLAG_W{reg_wr}} & ~reg_wdata;

  can_err_lock #(.LOCK_BITS(LOCK_BITS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .comm     (chan_comm),
    .strobe   (bit_strobe),
    .level    (bus_bit),
    .flag_now (flags[B_LOCK]),
    .lock_set (lock_set)
  );

  can_err_gate u_gate (
    .ev         (ev),
    .lock_set   (lock_set),
    .all_err_en (all_err_en),
    .proto_busy (|flags[PROTO_HI:PROTO_LO]),
    .set_vec    (set_vec)
  );

  for (genvar i = 0; i < FLAG_W; i++) begin : g_cell
    can_err_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .comm  (chan_comm),
      .set   (set_vec[i]),
      .clr   (clr_vec[i]),
      .q     (flags[i])
    );
  end

  assign reg_rdata = flags;
  assign err_irq   = |flags;
endmodule

// File: rtl/can_err_flags_chk.sv
module can_err_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        chan_comm,
  input logic        all_err_en,
  input logic        ev_ack_delim,
  input logic        ev_bit0,
  input logic        ev_bit1,
  input logic        ev_crc,
  input logic        ev_ack,
  input logic        ev_form,
  input logic        ev_stuff,
  input logic        ev_arb_lost,
  input logic        ev_overload,
  input logic        bit_strobe,
  input logic        bus_bit,
  input logic [15:0] reg_rdata,
  input logic        err_irq
);
  logic any_ev;
  assign any_ev = ev_ack_delim | ev_bit0 | ev_bit1 | ev_crc | ev_ack |
                  ev_form | ev_stuff | ev_arb_lost | ev_overload;

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ev && !bit_strobe) |=> ((reg_rdata & ~$past(reg_rdata)) == 16'h0)); // R3

  AST_ARB_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_comm && ev_arb_lost) |=> reg_rdata[2]); // R4

  AST_RESET_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_comm |=> (reg_rdata == 16'h0)); // R5

  AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_err_en && (reg_rdata[14:8] != 7'h0))
      |=> ((reg_rdata[14:8] & ~$past(reg_rdata[14:8])) == 7'h0)); // R6

  AST_LOCK_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[1]) |-> $past(bit_strobe && !bus_bit)); // R8

  AST_IRQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq == (reg_rdata != 16'h0)); // R11

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15] == 1'b0) && (reg_rdata[7:3] == 5'h0)); // R12
endmodule

bind can_err_flags can_err_flags_chk u_chk (.*);

// File: tb/can_err_flags_tb.sv
module can_err_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_comm = 1'b0;
  logic        all_err_en = 1'b1;
  logic [8:0]  ev = '0;   // [8]=ack_delim .. [0]=overload
  logic        bit_strobe = 1'b0;
  logic        bus_bit = 1'b1;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        err_irq;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] w; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  can_err_flags u_dut (
    .clk(clk), .rst_n(rst_n), .chan_comm(chan_comm), .all_err_en(all_err_en),
    .ev_ack_delim(ev[8]), .ev_bit0(ev[7]), .ev_bit1(ev[6]), .ev_crc(ev[5]),
    .ev_ack(ev[4]), .ev_form(ev[3]), .ev_stuff(ev[2]), .ev_arb_lost(ev[1]),
    .ev_overload(ev[0]), .bit_strobe(bit_strobe), .bus_bit(bus_bit),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_irq(err_irq)
  );

  // monitor: compares the word and the interrupt (R11) away from the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (reg_rdata !== it.w) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, reg_rdata, it.w);
      end
      checks++;
      if (err_irq !== (it.w != 16'h0)) begin
        bad++;
        $display("FAIL R11 (%s): irq=%b expected=%b", it.tag, err_irq, it.w != 16'h0);
      end
    end
  end

  task automatic tick; @(posedge clk); #1; endtask
  task automatic expect_w(input logic [15:0] w, input string tag);
    exp_t it; it.w = w; it.tag = tag; sb.push_back(it); tick();
  endtask
  task automatic pulse(input logic [8:0] v); ev = v; tick(); ev = '0; endtask
  task automatic wr(input logic [15:0] d);
    reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0; reg_wdata = '0;
  endtask
  task automatic strobes(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      bit_strobe = 1'b1; bus_bit = lvl; tick();
    end
    bit_strobe = 1'b0; bus_bit = 1'b1;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    expect_w(16'h0000, "R1");
    chan_comm = 1'b1; tick();

    pulse(9'h020); expect_w(16'h0800, "R2 crc");
    pulse(9'h004); expect_w(16'h0900, "R7 stuff with crc held");
    wr(16'hFFFF);  expect_w(16'h0900, "R3 write ones");
    wr(16'hF7FF);  expect_w(16'h0100, "R3 clear crc");
    wr(16'hFEFF);  expect_w(16'h0000, "R3 clear stuff");

    ev = 9'h002; reg_wr = 1'b1; reg_wdata = 16'h0000; tick();
    ev = '0; reg_wr = 1'b0;
    expect_w(16'h0004, "R4 set beats clear");
    pulse(9'h001); expect_w(16'h0005, "R2 overload");
    wr(16'h0000);  expect_w(16'h0000, "R3 clear all");

    all_err_en = 1'b0;
    pulse(9'h008); expect_w(16'h0200, "R6 first form");
    pulse(9'h010); expect_w(16'h0200, "R6 ack dropped");
    pulse(9'h002); expect_w(16'h0204, "R6 arb still sets");
    wr(16'h0000);
    pulse(9'h100); expect_w(16'h4000, "R6 ack delim after clear");
    wr(16'h0000);
    pulse(9'h080); expect_w(16'h2000, "R2 bit0");
    wr(16'h0000);  all_err_en = 1'b1;

    pulse(9'h020); expect_w(16'h0800, "R5 prep");
    chan_comm = 1'b0; tick(); expect_w(16'h0000, "R5 reset mode clears");
    pulse(9'h010); expect_w(16'h0000, "R5 event ignored");
    chan_comm = 1'b1; tick();

    strobes(31, 1'b0); expect_w(16'h0000, "R8 31 dominant");
    strobes(1, 1'b1);
    strobes(31, 1'b0); expect_w(16'h0000, "R8 restart after recessive");
    strobes(1, 1'b0);  expect_w(16'h0002, "R8 32nd dominant");
    strobes(40, 1'b0); expect_w(16'h0002, "R9 held");
    strobes(1, 1'b1);
    wr(16'hFFFD);      expect_w(16'h0000, "R9 clear");
    strobes(40, 1'b0); expect_w(16'h0000, "R9 early recessive no rearm");
    strobes(1, 1'b1);
    strobes(32, 1'b0); expect_w(16'h0002, "R9 rearmed");

    wr(16'h0000);
    strobes(32, 1'b0); expect_w(16'h0000, "R10 still disarmed");
    chan_comm = 1'b0; tick(); chan_comm = 1'b1; tick();
    strobes(32, 1'b0); expect_w(16'h0002, "R10 rearm via reset mode");

    pulse(9'h1FF); expect_w(16'h7F07, "R12 all set");
    wr(16'h0000);  expect_w(16'h0000, "R12 cleared");

    while (sb.size() > 0) tick();
    tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: run did not end");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule